// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor and the interrupt source side of a chip. It holds four pieces of state: the processor's current priority, an inter-processor interrupt (IPI) priority, the number of the pending source and that source's priority. Priorities are 8-bit and lower numbers win. Source 0 means nothing is pending, and source 2 is reserved for the IPI. The interrupt line to the processor is driven whenever a source is pending at a priority that beats the current priority.

The source side offers deliveries, each carrying a source number and a priority. Each offer gets an accept or refuse response one cycle later. An accepted delivery can push out a source that was already pending, and the presenter hands that source back as a one-cycle reject pulse so the source side can route it again. A refused delivery sets an internal flag. When the processor later lowers its priority or raises its IPI priority value, the presenter emits a one-cycle resend pulse and clears the flag.

The processor issues four commands: accept, set priority, set IPI priority and end-of-interrupt. The presenter handles one per cycle. Every response and event pulse is registered.

Top module: `irq_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the IPI priority is 0xFF, the pending priority is 0xFF and the pending source is 0. An accept command issued then returns 0x00000000, and irq_out is low.
- R2: A delivery at priority p, when no command is present in the same cycle, is accepted only if the current priority, the IPI priority and the pending priority are all numerically greater than p. The cycle after the offer, dlv_resp_valid is high and dlv_resp_ok tells whether the delivery was accepted.
- R3: When an accepted delivery, an IPI write or a priority raise displaces a pending source, that source number appears on rej_src with rej_valid high for one cycle. A displaced source equal to 2 (the IPI) or 0 is never reported.
- R4: A refused delivery latches a need-resend flag, and the flag survives until a resend is emitted.
- R5: irq_out is high exactly when the pending source is nonzero and the pending priority is numerically below the current priority.
- R6: cmd_op 0 (accept) returns, on acc_word one cycle later, the current priority in bits 31:24 and the pending source in bits 23:0. If the pending source was nonzero, the current priority becomes the pending priority, the pending priority becomes 0xFF and the pending source becomes 0.
- R7: cmd_op 2 writes cmd_data[7:0] to the IPI priority. If the value is below the current priority and at or below the pending priority, source 2 becomes pending at that priority.
- R8: A cmd_op 2 write with a value numerically larger than the old IPI priority pulses rsnd_valid if the need-resend flag was set, and clears the flag.
- R9: A cmd_op 1 write whose cmd_data[7:0] is numerically larger than the current priority loads it. It makes source 2 pending at the IPI priority if the IPI priority is below the new value and at or below the pending priority. It also pulses rsnd_valid and clears the flag if the flag was set.
- R10: A cmd_op 1 write with a numerically smaller value loads it, and if it is at or below the pending priority it rejects the pending source, clears it and sets the pending priority to 0xFF. A write of an equal value changes nothing.
- R11: cmd_op 3 (end-of-interrupt) applies cmd_data[31:24] as in R9 and, unless cmd_data[23:0] is 2, reports that source on eoi_src with eoi_valid high for one cycle.
- R12: A command and a delivery in the same cycle: the command is carried out, the delivery is refused and the need-resend flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 2 | 0 accept, 1 set priority, 2 set IPI priority, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| dlv_valid | input | 1 | Delivery offer present |
| dlv_src | input | 24 | Offered source number |
| dlv_pri | input | 8 | Offered priority |
| dlv_resp_valid | output | 1 | Delivery response pulse |
| dlv_resp_ok | output | 1 | Delivery accepted |
| acc_valid | output | 1 | Accept result pulse |
| acc_word | output | 32 | Priority and source returned by accept |
| rej_valid | output | 1 | Displaced-source pulse |
| rej_src | output | 24 | Displaced source number |
| rsnd_valid | output | 1 | Resend request pulse |
| eoi_valid | output | 1 | Completion pulse toward the source side |
| eoi_src | output | 24 | Completed source number |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Some properties are checked on every cycle. A pending non-IPI source always sits below the IPI priority. Reject and completion pulses never carry the IPI number. A resend pulse is preceded by a set flag. A delivery at or above the current priority, or one that collides with a command, is refused. An accept leaves the line low, and an equal priority write leaves state untouched. Other behaviour can only be shown by the bench's scenarios: the exact accept words, the identity of each displaced source, and a refused delivery's flag surviving until a later priority change. The same goes for the IPI re-pending after its own end-of-interrupt, and the equal-priority boundary of delivery.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
  localparam int unsigned PRI_W  = 8;
  localparam int unsigned SRC_W  = 24;
  localparam int unsigned WORD_W = PRI_W + SRC_W;

  typedef logic [PRI_W-1:0] pri_t;
  typedef logic [SRC_W-1:0] src_t;

  localparam pri_t PRI_IDLE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT = 2'd0,
    OP_SETPRI = 2'd1,
    OP_SETIPI = 2'd2,
    OP_EOI    = 2'd3
  } ipres_op_e;

  typedef struct packed {
    pri_t cppr;
    pri_t mfrr;
    pri_t pend;
    src_t xisr;
    logic need_resend;
  } ipres_state_t;

  typedef struct packed {
    logic              acc_v;
    logic [WORD_W-1:0] acc_w;
    logic              rej_v;
    src_t              rej_s;
    logic              rsnd_v;
    logic              eoi_v;
    src_t              eoi_s;
    logic              dr_v;
    logic              dr_ok;
  } ipres_evt_t;

  // a delivery fits only under all three thresholds
  function automatic logic can_present(pri_t cppr, pri_t mfrr, pri_t pend, pri_t p);
    return (cppr > p) && (mfrr > p) && (pend > p);
  endfunction

  // the IPI takes over when it beats the processor and ties or beats the pending one
  function automatic logic ipi_wins(pri_t mfrr, pri_t cppr, pri_t pend);
    return (mfrr < cppr) && (mfrr <= pend);
  endfunction

  function automatic logic line_level(ipres_state_t st);
    return (st.xisr != '0) && (st.pend < st.cppr);
  endfunction

  function automatic logic [WORD_W-1:0] pack_accept(pri_t cppr, src_t xisr);
    return {cppr, xisr};
  endfunction
endpackage

// File: rtl/ipres_deliver.sv
module ipres_deliver
  import irq_presenter_pkg::*;
(
  input  ipres_state_t st,
  input  pri_t         pri,
  output logic         fit
);
  assign fit = can_present(st.cppr, st.mfrr, st.pend, pri);
endmodule

// File: rtl/ipres_cmd.sv
module ipres_cmd
  import irq_presenter_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  ipres_state_t      st,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              dlv_valid,
  input  src_t              dlv_src,
  input  pri_t              dlv_pri,
  input  logic              dlv_fit,
  output ipres_state_t      nx,
  output ipres_evt_t        ev
);
  localparam src_t IPI_ID = SRC_W'(IPI_SRC);

  ipres_op_e op;
  pri_t      low_pri;
  pri_t      top_pri;
  src_t      eoi_id;
  pri_t      down_to;
  logic      lower;
  src_t      disp;

  assign op      = ipres_op_e'(cmd_op);
  assign low_pri = cmd_data[PRI_W-1:0];
  assign top_pri = cmd_data[WORD_W-1 -: PRI_W];
  assign eoi_id  = cmd_data[SRC_W-1:0];

  always_comb begin
    nx      = st;
    ev      = '0;
    lower   = 1'b0;
    down_to = st.cppr;
    disp    = '0;
    if (cmd_valid) begin
      unique case (op)
        OP_ACCEPT: begin
          ev.acc_v = 1'b1;
          ev.acc_w = pack_accept(st.cppr, st.xisr);
          if (st.xisr != '0) begin
            nx.cppr = st.pend;
            nx.pend = PRI_IDLE;
            nx.xisr = '0;
          end
        end
        OP_SETPRI: begin
          if (low_pri > st.cppr) begin
            lower   = 1'b1;
            down_to = low_pri;
          end else if (low_pri < st.cppr) begin
            nx.cppr = low_pri;
            if (low_pri <= st.pend) begin
              disp    = st.xisr;
              nx.xisr = '0;
              nx.pend = PRI_IDLE;
            end
          end
        end
        OP_SETIPI: begin
          nx.mfrr = low_pri;
          if (ipi_wins(low_pri, st.cppr, st.pend)) begin
            disp    = st.xisr;
            nx.pend = low_pri;
            nx.xisr = IPI_ID;
          end
          if (low_pri > st.mfrr) begin
            ev.rsnd_v      = st.need_resend;
            nx.need_resend = 1'b0;
          end
        end
        OP_EOI: begin
          lower   = 1'b1;
          down_to = top_pri;
          if (eoi_id != IPI_ID) begin
            ev.eoi_v = 1'b1;
            ev.eoi_s = eoi_id;
          end
        end
        default: ;
      endcase
      if (lower) begin
        nx.cppr = down_to;
        if (ipi_wins(st.mfrr, down_to, st.pend)) begin
          nx.pend = st.mfrr;
          nx.xisr = IPI_ID;
        end
        ev.rsnd_v      = st.need_resend;
        nx.need_resend = 1'b0;
      end
      if (dlv_valid) begin
        ev.dr_v        = 1'b1;
        nx.need_resend = 1'b1;
      end
    end else if (dlv_valid) begin
      ev.dr_v = 1'b1;
      if (dlv_fit) begin
        ev.dr_ok = 1'b1;
        disp     = st.xisr;
        nx.xisr  = dlv_src;
        nx.pend  = dlv_pri;
      end else begin
        nx.need_resend = 1'b1;
      end
    end
    ev.rej_v = (disp != '0) && (disp != IPI_ID);
    ev.rej_s = ev.rej_v ? disp : '0;
  end
endmodule

// File: rtl/ipres_pulse.sv
module ipres_pulse
  import irq_presenter_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ipres_evt_t ev,
  output ipres_evt_t ev_q
);
  localparam src_t IPI_ID = SRC_W'(IPI_SRC);

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev;
  end

  // R3
  reject_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.rej_v |-> (ev_q.rej_s != IPI_ID && ev_q.rej_s != '0));

  // R11
  eoi_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.eoi_v |-> (ev_q.eoi_s != IPI_ID));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              dlv_valid,
  input  logic [SRC_W-1:0]  dlv_src,
  input  logic [PRI_W-1:0]  dlv_pri,
  output logic              dlv_resp_valid,
  output logic              dlv_resp_ok,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_word,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              rsnd_valid,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              irq_out
);
  localparam src_t IPI_ID = SRC_W'(IPI_SRC);

  ipres_state_t st_q;
  ipres_state_t st_d;
  ipres_evt_t   ev;
  ipres_evt_t   ev_q;
  logic         dlv_fit;

  // named internal events, for the checks below
  logic ev_deliver_ok;
  logic ev_deliver_nak;
  logic ev_resend;
  assign ev_deliver_ok  = ev.dr_v & ev.dr_ok;
  assign ev_deliver_nak = ev.dr_v & ~ev.dr_ok;
  assign ev_resend      = ev.rsnd_v;

  ipres_deliver u_deliver (
    .st  (st_q),
    .pri (dlv_pri),
    .fit (dlv_fit)
  );

  ipres_cmd #(.IPI_SRC(IPI_SRC)) u_cmd (
    .st        (st_q),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .dlv_valid (dlv_valid),
    .dlv_src   (dlv_src),
    .dlv_pri   (dlv_pri),
    .dlv_fit   (dlv_fit),
    .nx        (st_d),
    .ev        (ev)
  );

  ipres_pulse #(.IPI_SRC(IPI_SRC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .ev_q  (ev_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q.cppr        <= '0;
      st_q.mfrr        <= PRI_IDLE;
      st_q.pend        <= PRI_IDLE;
      st_q.xisr        <= '0;
      st_q.need_resend <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  assign irq_out        = line_level(st_q);
  assign dlv_resp_valid = ev_q.dr_v;
  assign dlv_resp_ok    = ev_q.dr_ok;
  assign acc_valid      = ev_q.acc_v;
  assign acc_word       = ev_q.acc_w;
  assign rej_valid      = ev_q.rej_v;
  assign rej_src        = ev_q.rej_s;
  assign rsnd_valid     = ev_q.rsnd_v;
  assign eoi_valid      = ev_q.eoi_v;
  assign eoi_src        = ev_q.eoi_s;

  // R7
  ipi_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.xisr != '0 && st_q.xisr != IPI_ID) |-> (st_q.pend < st_q.mfrr));

  // R2
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !cmd_valid && dlv_pri >= st_q.cppr) |=> (dlv_resp_valid && !dlv_resp_ok));

  // R12
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dlv_valid) |=> (dlv_resp_valid && !dlv_resp_ok && !ev_deliver_ok));

  // R6
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=> !irq_out);

  // R10
  equal_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_data[PRI_W-1:0] == st_q.cppr && !dlv_valid)
      |=> ($stable(st_q.xisr) && $stable(st_q.cppr)));

  // R8
  resend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resend |-> st_q.need_resend);

  // R4
  nak_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deliver_nak |=> st_q.need_resend);
endmodule

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
module irq_presenter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = '0;
  logic        dlv_valid = 1'b0;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_pri = '0;
  logic        dlv_resp_valid, dlv_resp_ok, acc_valid, rej_valid, rsnd_valid, eoi_valid, irq_out;
  logic [31:0] acc_word;
  logic [23:0] rej_src, eoi_src;

  int n_chk = 0;
  int n_bad = 0;

  // captured outputs of the last step
  logic        c_rv, c_rok, c_av, c_jv, c_rs, c_ev, c_irq;
  logic [31:0] c_aw;
  logic [23:0] c_js, c_es;

  always #5 clk = ~clk;

  irq_presenter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_pri(dlv_pri),
    .dlv_resp_valid(dlv_resp_valid), .dlv_resp_ok(dlv_resp_ok),
    .acc_valid(acc_valid), .acc_word(acc_word), .rej_valid(rej_valid), .rej_src(rej_src),
    .rsnd_valid(rsnd_valid), .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [1:0] op, input logic [31:0] d,
                      input logic dv, input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    dlv_valid = dv; dlv_src = s; dlv_pri = p;
    @(negedge clk);
    c_rv = dlv_resp_valid; c_rok = dlv_resp_ok; c_av = acc_valid; c_aw = acc_word;
    c_jv = rej_valid; c_js = rej_src; c_rs = rsnd_valid; c_ev = eoi_valid; c_es = eoi_src;
    c_irq = irq_out;
    cmd_valid = 1'b0; dlv_valid = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    step(1'b1, op, d, 1'b0, '0, '0);
  endtask

  task automatic dlv(input logic [23:0] s, input logic [7:0] p);
    step(1'b0, 2'd0, '0, 1'b1, s, p);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", irq_out, 0);
    cmd(2'd0, '0);
    chk("R1 accept word", c_aw, 32'h0000_0000);
    chk("R6 accept valid", c_av, 1);
    dlv(24'h100, 8'h10);
    chk("R2 refused under cppr 0 valid", c_rv, 1);
    chk("R2 refused under cppr 0", c_rok, 0);
    cmd(2'd1, 32'hFF);
    chk("R4 R9 resend after lowering", c_rs, 1);
    chk("R9 no IPI with mfrr FF", c_irq, 0);
  endtask

  task automatic t_deliver;
    dlv(24'h100, 8'h40);
    chk("R2 accepted", c_rok, 1);
    chk("R3 no displaced", c_jv, 0);
    chk("R5 line up", c_irq, 1);
    dlv(24'h200, 8'h40);
    chk("R2 equal priority refused", c_rok, 0);
    dlv(24'h300, 8'h20);
    chk("R2 better accepted", c_rok, 1);
    chk("R3 displaced valid", c_jv, 1);
    chk("R3 displaced src", c_js, 24'h100);
  endtask

  task automatic t_accept;
    cmd(2'd0, '0);
    chk("R6 accept word", c_aw, 32'hFF00_0300);
    chk("R5 R6 line down", c_irq, 0);
    cmd(2'd0, '0);
    chk("R6 empty accept word", c_aw, 32'h2000_0000);
  endtask

  task automatic t_eoi;
    cmd(2'd3, 32'hFF00_0300);
    chk("R11 R4 resend on eoi", c_rs, 1);
    chk("R11 eoi valid", c_ev, 1);
    chk("R11 eoi src", c_es, 24'h300);
    cmd(2'd0, '0);
    chk("R11 cppr restored", c_aw, 32'hFF00_0000);
  endtask

  task automatic t_ipi;
    dlv(24'h400, 8'h50);
    cmd(2'd2, 32'h30);
    chk("R7 displaced valid", c_jv, 1);
    chk("R7 displaced src", c_js, 24'h400);
    chk("R7 line up", c_irq, 1);
    dlv(24'h500, 8'h10);
    chk("R3 IPI displacement silent", c_jv, 0);
    cmd(2'd0, '0);
    chk("R6 accept after IPI displaced", c_aw, 32'hFF00_0500);
    dlv(24'h600, 8'h20);
    chk("R2 refused by cppr 10", c_rok, 0);
    cmd(2'd2, 32'h40);
    chk("R8 resend on raise", c_rs, 1);
    cmd(2'd2, 32'h50);
    chk("R8 flag cleared", c_rs, 0);
  endtask

  task automatic t_lower;
    cmd(2'd1, 32'hFF);
    chk("R9 IPI pends on lowering", c_irq, 1);
    chk("R9 no resend", c_rs, 0);
    cmd(2'd0, '0);
    chk("R9 IPI accepted", c_aw, 32'hFF00_0002);
    cmd(2'd3, 32'hFF00_0002);
    chk("R11 IPI eoi silent", c_ev, 0);
    chk("R11 IPI re-pends", c_irq, 1);
    cmd(2'd2, 32'hFF);
    cmd(2'd0, '0);
    chk("R6 IPI again", c_aw, 32'hFF00_0002);
    cmd(2'd3, 32'hFF00_0002);
    chk("R9 no IPI with mfrr FF", c_irq, 0);
  endtask

  task automatic t_raise;
    dlv(24'h700, 8'h60);
    cmd(2'd1, 32'h60);
    chk("R10 reject on raise valid", c_jv, 1);
    chk("R10 reject on raise src", c_js, 24'h700);
    chk("R10 line down", c_irq, 0);
    dlv(24'h710, 8'h40);
    cmd(2'd1, 32'h60);
    chk("R10 equal write no reject", c_jv, 0);
    chk("R10 equal write keeps line", c_irq, 1);
    cmd(2'd1, 32'h50);
    chk("R10 raise above pending keeps", c_jv, 0);
    chk("R5 line with pend 40 cppr 50", c_irq, 1);
    cmd(2'd0, '0);
    chk("R10 accept word", c_aw, 32'h5000_0710);
  endtask

  task automatic t_collide;
    step(1'b1, 2'd0, '0, 1'b1, 24'h800, 8'h10);
    chk("R12 command done", c_aw, 32'h4000_0000);
    chk("R12 delivery answered", c_rv, 1);
    chk("R12 delivery refused", c_rok, 0);
    cmd(2'd1, 32'hFF);
    chk("R12 R4 flag latched", c_rs, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_deliver();
    t_accept();
    t_eoi();
    t_ipi();
    t_lower();
    t_raise();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule